// File: doc/BRIEF.md
# Paired Two-Lane Pipeline Stall Controller

This block sequences tokens through two parallel five-stage pipes, a primary lane and a secondary lane, whose stages are prefetch (PF), first decode (D1), address generation (D2), execute (EX) and write back (WB). Instructions arrive as pairs, one token per lane, and must retire in the order in which they were accepted. The controller carries no instruction semantics. It tracks only valid bits and tags per stage and decides which stage may move in each cycle.

The input side is a valid/ready stream. A pair is taken on a rising clock edge where `in_valid` and `in_ready` are both high. The sender must hold the pair stable while `in_valid` is high and `in_ready` is low. `in_ready` falls only when the PF stage holds a pair that cannot move on. PF, D1 and D2 hold a pair as one unit. One shared decode stall freezes D1 and D2, and also freezes PF while it is occupied. Each lane has its own execute stall, and these act asymmetrically. A stalled primary keeps the secondary in EX with it. A stalled secondary does not stop the primary from reaching WB.

The completion side is valid-only, with no back-pressure. One primary report and one secondary report can appear per cycle, and the primary report is the older of the two.

Top module: `pair_pipe_ctrl`

## Requirements
- R1: With no stall active, an accepted token is reported at completion in the fifth cycle after the cycle in which it was accepted. Back-to-back pairs complete one pair per cycle.
- R2: In PF, D1 and D2 a secondary token is valid only beside a valid primary of the same pair. The two tokens enter and leave each of these stages in the same cycle.
- R3: While `dec_stall` is high, the D1 and D2 contents hold with their tags unchanged. A pair in PF stays there, and nothing leaves D2 for EX.
- R4: While the primary token in EX is stalled, the secondary token in EX stays in EX and is not reported.
- R5: While the secondary token in EX is stalled, an unstalled primary token in EX moves to WB and is reported in the next cycle.
- R6: A pair enters EX only in a cycle where both tokens of the previous pair leave EX or have already left.
- R7: The concatenated completion stream matches acceptance order. Pairs are reported in the order accepted. Within a pair the primary comes first. Within one cycle `cmp_p_*` is older than `cmp_s_*`.
- R8: A pair accepted with `in_s_vld` low carries a bubble in the secondary lane, and no secondary completion is reported for it.
- R9: `in_ready` is low only while PF holds a pair that cannot advance. An empty PF accepts even during `dec_stall`.
- R10: Synchronous reset (`rst` high at a clock edge) clears every stage valid bit in both lanes and both completion valids.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Pair offered |
| in_ready | output | 1 | Pair can be taken this cycle |
| in_p_tag | input | TAG_W | Primary token tag |
| in_s_vld | input | 1 | Pair carries a secondary token |
| in_s_tag | input | TAG_W | Secondary token tag |
| dec_stall | input | 1 | Shared stall for the decode stages |
| p_ex_stall | input | 1 | Primary lane execute stall |
| s_ex_stall | input | 1 | Secondary lane execute stall |
| p_stg_vld | output | 5 | Primary valid per stage, bit 0 = PF … bit 4 = WB |
| s_stg_vld | output | 5 | Secondary valid per stage, same order |
| p_stg_tag | output | 5*TAG_W | Primary tag per stage, stage k at bits k*TAG_W upward |
| s_stg_tag | output | 5*TAG_W | Secondary tag per stage, same packing |
| cmp_p_vld | output | 1 | Primary completion this cycle |
| cmp_p_tag | output | TAG_W | Tag of the completing primary |
| cmp_s_vld | output | 1 | Secondary completion this cycle |
| cmp_s_tag | output | TAG_W | Tag of the completing secondary |

## Verification
The bench builds the block with its default 8-bit tag. Tags are derived from a pair counter (2n and 2n+1), so the expected order and the pairing within each front stage follow by arithmetic, and the long run wraps the tag space. A sweep over every sequence of two consecutive input combinations, covering offer, secondary presence and the three stall inputs, reaches every ordering of decode stall, primary stall and secondary stall that can occur against a pair sitting in EX.

// File: rtl/pair_pipe_pkg.sv
package pair_pipe_pkg;

  typedef enum int {
    STG_PF = 0,
    STG_D1 = 1,
    STG_D2 = 2,
    STG_EX = 3,
    STG_WB = 4
  } stg_e;

  localparam int FRONT_DEPTH = 3;
  localparam int N_STG       = FRONT_DEPTH + 2;
  localparam int N_LANES     = 2;
  localparam int LANE_P      = 0;
  localparam int LANE_S      = 1;

endpackage

// File: rtl/pair_pipe_front.sv
module pair_pipe_front
  import pair_pipe_pkg::*;
#(
  parameter int TAG_W = 8,
  parameter int DEPTH = FRONT_DEPTH
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   hold,
  input  logic                   in_valid,
  input  logic [TAG_W-1:0]       in_p_tag,
  input  logic                   in_s_vld,
  input  logic [TAG_W-1:0]       in_s_tag,
  output logic                   in_ready,
  input  logic                   out_ok,
  output logic                   out_fire,
  output logic [TAG_W-1:0]       out_p_tag,
  output logic                   out_s_vld,
  output logic [TAG_W-1:0]       out_s_tag,
  output logic [DEPTH-1:0]       stg_p_vld,
  output logic [DEPTH-1:0]       stg_s_vld,
  output logic [DEPTH*TAG_W-1:0] stg_p_tag,
  output logic [DEPTH*TAG_W-1:0] stg_s_tag
);

  localparam int LAST = DEPTH - 1;

  logic [DEPTH-1:0] v_q;
  logic [DEPTH-1:0] sv_q;
  logic [DEPTH-1:0] open;
  logic [TAG_W-1:0] pt_q [DEPTH];
  logic [TAG_W-1:0] st_q [DEPTH];

  // A stage can take new contents when it is empty or its own contents move on.
  // Decode stages (index > 0) are frozen while hold is high; PF only when full.
  always_comb begin : open_chain
    logic nxt;
    nxt = out_ok;
    for (int k = LAST; k >= 0; k--) begin
      open[k] = !(hold && (k != 0)) && (!v_q[k] || nxt);
      nxt     = open[k];
    end
  end

  for (genvar k = 0; k < DEPTH; k++) begin : g_stg
    if (k == 0) begin : g_head
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q[k]  <= 1'b0;
          sv_q[k] <= 1'b0;
        end else if (open[k]) begin
          v_q[k]  <= in_valid;
          sv_q[k] <= in_valid && in_s_vld;
        end
      end
      always_ff @(posedge clk) begin
        if (open[k]) begin
          pt_q[k] <= in_p_tag;
          st_q[k] <= in_s_tag;
        end
      end
    end else begin : g_body
      always_ff @(posedge clk) begin
        if (rst) begin
          v_q[k]  <= 1'b0;
          sv_q[k] <= 1'b0;
        end else if (open[k]) begin
          v_q[k]  <= v_q[k-1];
          sv_q[k] <= sv_q[k-1];
        end
      end
      always_ff @(posedge clk) begin
        if (open[k]) begin
          pt_q[k] <= pt_q[k-1];
          st_q[k] <= st_q[k-1];
        end
      end
    end
    assign stg_p_tag[k*TAG_W +: TAG_W] = pt_q[k];
    assign stg_s_tag[k*TAG_W +: TAG_W] = st_q[k];
  end

  assign in_ready  = open[0];
  assign out_fire  = v_q[LAST] && !hold && out_ok;
  assign out_p_tag = pt_q[LAST];
  assign out_s_vld = sv_q[LAST];
  assign out_s_tag = st_q[LAST];
  assign stg_p_vld = v_q;
  assign stg_s_vld = sv_q;

endmodule

// File: rtl/pair_pipe_issue.sv
module pair_pipe_issue (
  input  logic p_ex_v,
  input  logic s_ex_v,
  input  logic p_ex_stall,
  input  logic s_ex_stall,
  output logic p_go,
  output logic s_go,
  output logic ex_free
);

  logic p_blocked;

  // Primary is never held by the secondary; secondary waits on a stalled primary.
  assign p_blocked = p_ex_v && p_ex_stall;
  assign p_go      = p_ex_v && !p_ex_stall;
  assign s_go      = s_ex_v && !s_ex_stall && !p_blocked;
  // EX takes the next pair only when both lanes vacate it this cycle.
  assign ex_free   = (!p_ex_v || p_go) && (!s_ex_v || s_go);

endmodule

// File: rtl/pair_pipe_lane.sv
module pair_pipe_lane #(
  parameter int TAG_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic             load_v,
  input  logic [TAG_W-1:0] load_tag,
  input  logic             go,
  output logic             ex_v,
  output logic [TAG_W-1:0] ex_tag,
  output logic             wb_v,
  output logic [TAG_W-1:0] wb_tag
);

  always_ff @(posedge clk) begin
    if (rst) begin
      ex_v <= 1'b0;
      wb_v <= 1'b0;
    end else begin
      wb_v <= go;
      if (load) begin
        ex_v <= load_v;
      end else if (go) begin
        ex_v <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (load) begin
      ex_tag <= load_tag;
    end
    if (go) begin
      wb_tag <= ex_tag;
    end
  end

endmodule

// File: rtl/pair_pipe_ctrl.sv
module pair_pipe_ctrl
  import pair_pipe_pkg::*;
#(
  parameter int TAG_W = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   in_valid,
  output logic                   in_ready,
  input  logic [TAG_W-1:0]       in_p_tag,
  input  logic                   in_s_vld,
  input  logic [TAG_W-1:0]       in_s_tag,
  input  logic                   dec_stall,
  input  logic                   p_ex_stall,
  input  logic                   s_ex_stall,
  output logic [N_STG-1:0]       p_stg_vld,
  output logic [N_STG-1:0]       s_stg_vld,
  output logic [N_STG*TAG_W-1:0] p_stg_tag,
  output logic [N_STG*TAG_W-1:0] s_stg_tag,
  output logic                   cmp_p_vld,
  output logic [TAG_W-1:0]       cmp_p_tag,
  output logic                   cmp_s_vld,
  output logic [TAG_W-1:0]       cmp_s_tag
);

  logic                         fr_fire;
  logic [TAG_W-1:0]             fr_p_tag;
  logic                         fr_s_vld;
  logic [TAG_W-1:0]             fr_s_tag;
  logic [FRONT_DEPTH-1:0]       fr_p_vld_v;
  logic [FRONT_DEPTH-1:0]       fr_s_vld_v;
  logic [FRONT_DEPTH*TAG_W-1:0] fr_p_tag_v;
  logic [FRONT_DEPTH*TAG_W-1:0] fr_s_tag_v;
  logic                         ex_free;

  logic [N_LANES-1:0] ln_ldv;
  logic [N_LANES-1:0] ln_go;
  logic [N_LANES-1:0] ln_exv;
  logic [N_LANES-1:0] ln_wbv;
  logic [TAG_W-1:0]   ln_ldtag [N_LANES];
  logic [TAG_W-1:0]   ln_extag [N_LANES];
  logic [TAG_W-1:0]   ln_wbtag [N_LANES];

  pair_pipe_front #(
    .TAG_W (TAG_W),
    .DEPTH (FRONT_DEPTH)
  ) u_front (
    .clk       (clk),
    .rst       (rst),
    .hold      (dec_stall),
    .in_valid  (in_valid),
    .in_p_tag  (in_p_tag),
    .in_s_vld  (in_s_vld),
    .in_s_tag  (in_s_tag),
    .in_ready  (in_ready),
    .out_ok    (ex_free),
    .out_fire  (fr_fire),
    .out_p_tag (fr_p_tag),
    .out_s_vld (fr_s_vld),
    .out_s_tag (fr_s_tag),
    .stg_p_vld (fr_p_vld_v),
    .stg_s_vld (fr_s_vld_v),
    .stg_p_tag (fr_p_tag_v),
    .stg_s_tag (fr_s_tag_v)
  );

  pair_pipe_issue u_issue (
    .p_ex_v     (ln_exv[LANE_P]),
    .s_ex_v     (ln_exv[LANE_S]),
    .p_ex_stall (p_ex_stall),
    .s_ex_stall (s_ex_stall),
    .p_go       (ln_go[LANE_P]),
    .s_go       (ln_go[LANE_S]),
    .ex_free    (ex_free)
  );

  assign ln_ldv[LANE_P]   = 1'b1;
  assign ln_ldv[LANE_S]   = fr_s_vld;
  assign ln_ldtag[LANE_P] = fr_p_tag;
  assign ln_ldtag[LANE_S] = fr_s_tag;

  for (genvar l = 0; l < N_LANES; l++) begin : g_lane
    pair_pipe_lane #(
      .TAG_W (TAG_W)
    ) u_lane (
      .clk      (clk),
      .rst      (rst),
      .load     (fr_fire),
      .load_v   (ln_ldv[l]),
      .load_tag (ln_ldtag[l]),
      .go       (ln_go[l]),
      .ex_v     (ln_exv[l]),
      .ex_tag   (ln_extag[l]),
      .wb_v     (ln_wbv[l]),
      .wb_tag   (ln_wbtag[l])
    );
  end

  assign p_stg_vld = {ln_wbv[LANE_P], ln_exv[LANE_P], fr_p_vld_v};
  assign s_stg_vld = {ln_wbv[LANE_S], ln_exv[LANE_S], fr_s_vld_v};
  assign p_stg_tag = {ln_wbtag[LANE_P], ln_extag[LANE_P], fr_p_tag_v};
  assign s_stg_tag = {ln_wbtag[LANE_S], ln_extag[LANE_S], fr_s_tag_v};

  assign cmp_p_vld = p_stg_vld[STG_WB];
  assign cmp_p_tag = ln_wbtag[LANE_P];
  assign cmp_s_vld = s_stg_vld[STG_WB];
  assign cmp_s_tag = ln_wbtag[LANE_S];

endmodule

// File: rtl/pair_pipe_ctrl_chk.sv
module pair_pipe_ctrl_chk #(
  parameter int TAG_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             in_ready,
  input logic             dec_stall,
  input logic             p_ex_stall,
  input logic             s_ex_stall,
  input logic [4:0]       p_stg_vld,
  input logic [4:0]       s_stg_vld,
  input logic [TAG_W-1:0] p_d1_tag,
  input logic [TAG_W-1:0] p_d2_tag,
  input logic [TAG_W-1:0] s_d2_tag,
  input logic [TAG_W-1:0] p_ex_tag,
  input logic [TAG_W-1:0] s_ex_tag,
  input logic             cmp_p_vld,
  input logic [TAG_W-1:0] cmp_p_tag,
  input logic             cmp_s_vld
);

  p_pair_front_r2: assert property (@(posedge clk) disable iff (rst)
    s_stg_vld[2] |-> p_stg_vld[2]);

  p_d1_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (dec_stall && p_stg_vld[1]) |=> (p_stg_vld[1] && $stable(p_d1_tag)));

  p_d2_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (dec_stall && p_stg_vld[2]) |=> (p_stg_vld[2] && $stable(p_d2_tag)));

  p_d2_s_hold_r3: assert property (@(posedge clk) disable iff (rst)
    (dec_stall && s_stg_vld[2]) |=> (s_stg_vld[2] && $stable(s_d2_tag)));

  p_prim_holds_sec_r4: assert property (@(posedge clk) disable iff (rst)
    (p_stg_vld[3] && p_ex_stall && s_stg_vld[3])
      |=> (s_stg_vld[3] && $stable(s_ex_tag) && !cmp_s_vld));

  p_prim_free_r5: assert property (@(posedge clk) disable iff (rst)
    (p_stg_vld[3] && !p_ex_stall) |=> (cmp_p_vld && cmp_p_tag == $past(p_ex_tag)));

  p_no_overtake_r6: assert property (@(posedge clk) disable iff (rst)
    (s_stg_vld[3] && (s_ex_stall || (p_stg_vld[3] && p_ex_stall)))
      |=> (!p_stg_vld[3] || ($past(p_stg_vld[3]) && $stable(p_ex_tag))));

  p_lone_prim_r8: assert property (@(posedge clk) disable iff (rst)
    (p_stg_vld[3] && !s_stg_vld[3]) |=> !cmp_s_vld);

  p_ready_r9: assert property (@(posedge clk) disable iff (rst)
    !in_ready |-> p_stg_vld[0]);

  p_reset_clear_r10: assert property (@(posedge clk)
    rst |=> (p_stg_vld == 5'd0 && s_stg_vld == 5'd0));

endmodule

bind pair_pipe_ctrl pair_pipe_ctrl_chk #(.TAG_W(TAG_W)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .in_ready   (in_ready),
  .dec_stall  (dec_stall),
  .p_ex_stall (p_ex_stall),
  .s_ex_stall (s_ex_stall),
  .p_stg_vld  (p_stg_vld),
  .s_stg_vld  (s_stg_vld),
  .p_d1_tag   (p_stg_tag[1*TAG_W +: TAG_W]),
  .p_d2_tag   (p_stg_tag[2*TAG_W +: TAG_W]),
  .s_d2_tag   (s_stg_tag[2*TAG_W +: TAG_W]),
  .p_ex_tag   (p_stg_tag[3*TAG_W +: TAG_W]),
  .s_ex_tag   (s_stg_tag[3*TAG_W +: TAG_W]),
  .cmp_p_vld  (cmp_p_vld),
  .cmp_p_tag  (cmp_p_tag),
  .cmp_s_vld  (cmp_s_vld)
);

// File: tb/pair_pipe_ctrl_test.sv
module pair_pipe_ctrl_test;

  localparam int CLK_PERIOD = 10;
  localparam int TW         = 8;
  localparam int QD         = 4096;

  logic            clk = 1'b0;
  logic            rst = 1'b1;
  logic            in_valid = 1'b0;
  logic            in_ready;
  logic [TW-1:0]   in_p_tag;
  logic            in_s_vld = 1'b0;
  logic [TW-1:0]   in_s_tag;
  logic            dec_stall = 1'b0;
  logic            p_ex_stall = 1'b0;
  logic            s_ex_stall = 1'b0;
  logic [4:0]      p_stg_vld;
  logic [4:0]      s_stg_vld;
  logic [5*TW-1:0] p_stg_tag;
  logic [5*TW-1:0] s_stg_tag;
  logic            cmp_p_vld;
  logic [TW-1:0]   cmp_p_tag;
  logic            cmp_s_vld;
  logic [TW-1:0]   cmp_s_tag;

  int n_vec = 0;
  int n_bad = 0;
  int pc    = 0;
  int cyc   = 0;
  int wr    = 0;
  int rd    = 0;
  bit fire_q   = 1'b0;
  bit lat_mode = 1'b0;
  logic [TW-1:0] q_tag [QD];
  int            q_cyc [QD];
  bit            q_lat [QD];
  logic [TW-1:0] held_tag;

  assign in_p_tag = TW'(2 * pc);
  assign in_s_tag = TW'(2 * pc + 1);

  always #(CLK_PERIOD / 2) clk = ~clk;

  pair_pipe_ctrl #(.TAG_W(TW)) uut (
    .clk        (clk),
    .rst        (rst),
    .in_valid   (in_valid),
    .in_ready   (in_ready),
    .in_p_tag   (in_p_tag),
    .in_s_vld   (in_s_vld),
    .in_s_tag   (in_s_tag),
    .dec_stall  (dec_stall),
    .p_ex_stall (p_ex_stall),
    .s_ex_stall (s_ex_stall),
    .p_stg_vld  (p_stg_vld),
    .s_stg_vld  (s_stg_vld),
    .p_stg_tag  (p_stg_tag),
    .s_stg_tag  (s_stg_tag),
    .cmp_p_vld  (cmp_p_vld),
    .cmp_p_tag  (cmp_p_tag),
    .cmp_s_vld  (cmp_s_vld),
    .cmp_s_tag  (cmp_s_tag)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_vec++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pop(input logic [TW-1:0] tag, input string req);
    if (rd == wr) begin
      chk(1'b0, req, int'(tag), -1);
    end else begin
      chk(tag == q_tag[rd % QD], req, int'(tag), int'(q_tag[rd % QD]));
      if (q_lat[rd % QD]) begin
        chk(cyc - q_cyc[rd % QD] == 5, "R1 latency", cyc - q_cyc[rd % QD], 5);
      end
      rd++;
    end
  endtask

  task automatic push(input logic [TW-1:0] tag);
    q_tag[wr % QD] = tag;
    q_cyc[wr % QD] = cyc;
    q_lat[wr % QD] = lat_mode;
    wr++;
  endtask

  // Completion order (R7), front pairing (R2) and acceptance bookkeeping.
  always @(negedge clk) begin
    cyc++;
    if (!rst) begin
      if (cmp_p_vld) pop(cmp_p_tag, "R7 primary order");
      if (cmp_s_vld) pop(cmp_s_tag, "R7 secondary order");
      for (int k = 0; k < 3; k++) begin
        if (s_stg_vld[k]) begin
          chk(p_stg_vld[k] && (s_stg_tag[k*TW +: TW] == TW'(p_stg_tag[k*TW +: TW] + 1)),
              "R2 pair lockstep", int'(s_stg_tag[k*TW +: TW]),
              int'(TW'(p_stg_tag[k*TW +: TW] + 1)));
        end
      end
    end
    fire_q = in_valid && in_ready && !rst;
    if (fire_q) begin
      push(in_p_tag);
      if (in_s_vld) push(in_s_tag);
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
    if (fire_q) pc++;
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    repeat (3) step();
    rst = 1'b0;
    #1;
    // R10: reset state
    chk(p_stg_vld == 0 && s_stg_vld == 0 && !cmp_p_vld && !cmp_s_vld, "R10 reset state",
        int'({p_stg_vld, s_stg_vld}), 0);
    chk(in_ready, "R9 ready when empty", int'(in_ready), 1);

    // R1: back-to-back stream without stalls
    lat_mode = 1'b1;
    in_valid = 1'b1;
    in_s_vld = 1'b1;
    repeat (8) step();
    in_valid = 1'b0;
    lat_mode = 1'b0;
    repeat (8) step();
    chk(rd == wr, "R1 stream drained", rd, wr);

    // R8: pair without a secondary token
    in_valid = 1'b1;
    in_s_vld = 1'b0;
    step();
    in_valid = 1'b0;
    chk(p_stg_vld[0] && !s_stg_vld[0], "R8 bubble in PF", int'(s_stg_vld[0]), 0);
    for (int i = 0; i < 3; i++) begin
      step();
      chk(s_stg_vld == 0 && !cmp_s_vld, "R8 secondary empty", int'(s_stg_vld), 0);
    end
    step();
    chk(cmp_p_vld && !cmp_s_vld, "R8 lone completion", int'({cmp_p_vld, cmp_s_vld}), 2);
    step();

    // R4: primary execute stall holds the secondary
    in_valid = 1'b1;
    in_s_vld = 1'b1;
    step();
    in_valid = 1'b0;
    repeat (3) step();
    chk(p_stg_vld[3] && s_stg_vld[3], "R4 pair in EX", int'({p_stg_vld[3], s_stg_vld[3]}), 3);
    p_ex_stall = 1'b1;
    s_ex_stall = 1'b0;
    for (int i = 0; i < 3; i++) begin
      step();
      chk(p_stg_vld[3] && s_stg_vld[3] && !cmp_p_vld && !cmp_s_vld, "R4 secondary held",
          int'({p_stg_vld[3], s_stg_vld[3], cmp_p_vld, cmp_s_vld}), 12);
    end
    p_ex_stall = 1'b0;
    step();
    chk(cmp_p_vld && cmp_s_vld, "R4 release", int'({cmp_p_vld, cmp_s_vld}), 3);
    step();

    // R5/R6: secondary stall, primary passes, next pair waits in D2
    in_valid = 1'b1;
    step();
    step();
    in_valid = 1'b0;
    step();
    step();
    s_ex_stall = 1'b1;
    step();
    chk(cmp_p_vld && !cmp_s_vld && s_stg_vld[3], "R5 primary passes",
        int'({cmp_p_vld, cmp_s_vld, s_stg_vld[3]}), 5);
    chk(!p_stg_vld[3] && p_stg_vld[2], "R6 next pair waits",
        int'({p_stg_vld[3], p_stg_vld[2]}), 1);
    step();
    chk(!p_stg_vld[3] && p_stg_vld[2] && !cmp_p_vld, "R6 still waiting",
        int'({p_stg_vld[3], p_stg_vld[2], cmp_p_vld}), 2);
    s_ex_stall = 1'b0;
    step();
    chk(cmp_s_vld && p_stg_vld[3] && s_stg_vld[3], "R6 entry after release",
        int'({cmp_s_vld, p_stg_vld[3], s_stg_vld[3]}), 7);
    step();
    chk(cmp_p_vld && cmp_s_vld, "R5 second pair done", int'({cmp_p_vld, cmp_s_vld}), 3);
    step();

    // R3/R9: decode stall
    dec_stall = 1'b1;
    in_valid  = 1'b1;
    step();
    #1;
    chk(!in_ready, "R9 ready low with PF stuck", int'(in_ready), 0);
    step();
    chk(p_stg_vld == 5'b00001 && !in_ready, "R3 PF held", int'(p_stg_vld), 1);
    dec_stall = 1'b0;
    #1;
    chk(in_ready, "R9 ready back", int'(in_ready), 1);
    step();
    step();
    held_tag  = p_stg_tag[2*TW +: TW];
    dec_stall = 1'b1;
    for (int i = 0; i < 2; i++) begin
      step();
      chk(p_stg_vld[2:0] == 3'b111 && p_stg_tag[2*TW +: TW] == held_tag && !p_stg_vld[3],
          "R3 decode frozen", int'(p_stg_tag[2*TW +: TW]), int'(held_tag));
    end
    dec_stall = 1'b0;
    in_valid  = 1'b0;
    repeat (10) step();
    chk(rd == wr, "R7 drained after stalls", rd, wr);

    // R10: reset in mid-flow
    in_valid = 1'b1;
    repeat (4) step();
    in_valid = 1'b0;
    rst = 1'b1;
    step();
    chk(p_stg_vld == 0 && s_stg_vld == 0 && !cmp_p_vld && !cmp_s_vld, "R10 flush",
        int'({p_stg_vld, s_stg_vld}), 0);
    rd = wr;
    rst = 1'b0;
    step();

    // Sweep every pair of consecutive input combinations (R7 order checked by monitor)
    for (int c = 0; c < 1024; c++) begin
      for (int h = 0; h < 2; h++) begin
        logic [4:0] b;
        b = (h == 0) ? c[4:0] : c[9:5];
        in_valid   = b[0];
        in_s_vld   = b[1];
        dec_stall  = b[2];
        p_ex_stall = b[3];
        s_ex_stall = b[4];
        step();
      end
    end
    in_valid   = 1'b0;
    dec_stall  = 1'b0;
    p_ex_stall = 1'b0;
    s_ex_stall = 1'b0;
    repeat (12) step();
    chk(rd == wr, "R7 sweep drained", rd, wr);

    finish_run();
  end

endmodule